// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block places one scan cell on every signal that crosses between the core logic and the device pins. Input pins feed the core through an input cell, and core outputs reach the pins through an output cell. In functional operation the cells are transparent. When the test-mode select is high, the pins and the core-side inputs are driven from per-cell update registers. Those registers are loaded serially from the test data input.

The block does not sequence itself. An external test access controller drives three strobes, all synchronous to the test clock. The capture strobe samples the parallel values into the shift flops. The shift strobe moves the chain one position toward the test data output. The update strobe copies the shift flops into the update registers. Because the serial path runs from `tdi` to `tdo`, several devices can be daisy-chained on shared clock and mode lines, and each device adds exactly one shift position per cell.

Top module: `bscan_chain`

## Requirements
- R1: With `test_mode` low, `pin_out` equals `core_out` and `core_in` equals `pin_in` in the same cycle, whatever the update registers hold.
- R2: With `test_mode` high, `pin_out[j]` is the update register of output cell j and `core_in[j]` is the update register of input cell j.
- R3: A cycle with `cap_en` high loads input cell j with `pin_in[j]` and output cell j with `core_out[j]`. Chain position k is input cell k for k < NUM_IN and output cell k-NUM_IN otherwise.
- R4: A cycle with `shift_en` high (and `cap_en` low) moves every shift flop one position: position 0 takes `tdi`, and position k takes position k-1. `tdo` is always position LEN-1, so the first bit shifted out is output cell NUM_OUT-1.
- R5: A cycle with `upd_en` high copies every shift flop into its update register. Without `upd_en` the update registers keep their value, including while new data is shifted in.
- R6: When `cap_en` and `shift_en` are both high, capture wins and the shift flops take the parallel values.
- R7: When `upd_en` and `shift_en` are both high, the update registers take the shift-flop contents from before that shift.
- R8: Synchronous active-high `rst` clears all shift flops and update registers to 0, so `tdo` is 0 and, in test mode, `pin_out` and `core_in` are all 0.
- R9: A bit presented on `tdi` reaches `tdo` after exactly LEN = NUM_IN+NUM_OUT shift cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| test_mode | input | 1 | Selects update registers over functional paths |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (last chain position) |
| pin_in | input | NUM_IN | Values arriving from input pins |
| core_in | output | NUM_IN | Values delivered to the core |
| core_out | input | NUM_OUT | Values produced by the core |
| pin_out | output | NUM_OUT | Values driven to output pins |

## Verification
Two pairs of functions can land in one cycle. Update can coincide with shift, because each cell's update register reads the same shift flop that the shift is overwriting. Capture can also coincide with shift, because both write the shift flop. The bench first loads a known pattern serially. It then raises update together with one further shift, and judges the pins in test mode against the pattern from before that shift. For the second pair it raises capture and shift together on a chain that holds a different pattern, then unloads the chain and expects the captured pin and core values rather than a shifted copy.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef struct packed {
        logic cap;
        logic shift;
        logic upd;
    } bscan_ctrl_t;

    function automatic int chain_len(input int n_in, input int n_out);
        return n_in + n_out;
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bscan_ctrl_t ctrl,
    input  logic        par_in,
    input  logic        ser_in,
    output logic        shf_q,
    output logic        upd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q <= 1'b0;
        end else if (ctrl.cap) begin
            shf_q <= par_in;
        end else if (ctrl.shift) begin
            shf_q <= ser_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q <= 1'b0;
        end else if (ctrl.upd) begin
            upd_q <= shf_q;
        end
    end

    // R3 / R6: capture has priority over shift
    a_r6_capture_wins: assert property (@(posedge clk) disable iff (rst)
        ctrl.cap |=> shf_q == $past(par_in));

    // R4: serial move
    a_r4_shift_moves: assert property (@(posedge clk) disable iff (rst)
        (ctrl.shift && !ctrl.cap) |=> shf_q == $past(ser_in));

    // R5 / R7: update takes pre-edge shift value
    a_r7_update_old_value: assert property (@(posedge clk) disable iff (rst)
        ctrl.upd |=> upd_q == $past(shf_q));

    // R5: hold without update
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl.upd |=> $stable(upd_q));

    // R8: reset clears both registers
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (shf_q == 1'b0 && upd_q == 1'b0));

endmodule

// File: rtl/bscan_mux.sv
module bscan_mux #(
    parameter int W = 4
) (
    input  logic         test_mode,
    input  logic [W-1:0] func_val,
    input  logic [W-1:0] held_val,
    output logic [W-1:0] y
);

    always_comb begin
        y = test_mode ? held_val : func_val;
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic               shift_en,
    input  logic               upd_en,
    input  logic               test_mode,
    input  logic               tdi,
    output logic               tdo,
    input  logic [NUM_IN-1:0]  pin_in,
    output logic [NUM_IN-1:0]  core_in,
    input  logic [NUM_OUT-1:0] core_out,
    output logic [NUM_OUT-1:0] pin_out
);

    localparam int LEN = chain_len(NUM_IN, NUM_OUT);

    bscan_ctrl_t      ctrl;
    logic [LEN-1:0]   par_vec;
    logic [LEN-1:0]   ser_vec;
    logic [LEN-1:0]   shf_vec;
    logic [LEN-1:0]   upd_vec;

    assign ctrl    = '{cap: cap_en, shift: shift_en, upd: upd_en};
    assign par_vec = {core_out, pin_in};
    assign ser_vec = {shf_vec[LEN-2:0], tdi};
    assign tdo     = shf_vec[LEN-1];

    for (genvar k = 0; k < LEN; k++) begin : g_cell
        bscan_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .ctrl   (ctrl),
            .par_in (par_vec[k]),
            .ser_in (ser_vec[k]),
            .shf_q  (shf_vec[k]),
            .upd_q  (upd_vec[k])
        );
    end

    bscan_mux #(.W(NUM_IN)) u_in_mux (
        .test_mode (test_mode),
        .func_val  (pin_in),
        .held_val  (upd_vec[NUM_IN-1:0]),
        .y         (core_in)
    );

    bscan_mux #(.W(NUM_OUT)) u_out_mux (
        .test_mode (test_mode),
        .func_val  (core_out),
        .held_val  (upd_vec[LEN-1:NUM_IN]),
        .y         (pin_out)
    );

    // R1: transparent in functional mode
    a_r1_transparent: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> (pin_out == core_out && core_in == pin_in));

    // R8: serial output is 0 right after reset
    a_r8_tdo_zero: assert property (@(posedge clk)
        rst |=> !tdo);

endmodule

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;

    localparam int PERIOD  = 10;
    localparam int NUM_IN  = 4;
    localparam int NUM_OUT = 4;
    localparam int LEN     = NUM_IN + NUM_OUT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, test_mode = 1'b0, tdi = 1'b0;
    logic tdo;
    logic [NUM_IN-1:0]  pin_in = '0;
    logic [NUM_IN-1:0]  core_in;
    logic [NUM_OUT-1:0] core_out = '0;
    logic [NUM_OUT-1:0] pin_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    bscan_chain #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) dut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en),
        .upd_en(upd_en), .test_mode(test_mode), .tdi(tdi), .tdo(tdo),
        .pin_in(pin_in), .core_in(core_in), .core_out(core_out),
        .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Shift all LEN positions: cell k ends up holding cells[k];
    // returns the previous content of cell k in old_cells[k].
    task automatic shift_chain(input logic [LEN-1:0] cells, output logic [LEN-1:0] old_cells);
        for (int i = 0; i < LEN; i++) begin
            @(negedge clk);
            old_cells[LEN-1-i] = tdo;
            tdi      = cells[LEN-1-i];
            shift_en = 1'b1;
        end
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk);
        upd_en = 1'b1;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [LEN-1:0] old;
        test_mode = 1'b1;
        @(negedge clk);
        check("R8 pin_out", 32'(pin_out), 0);
        check("R8 core_in", 32'(core_in), 0);
        check("R8 tdo", 32'(tdo), 0);
        shift_chain('0, old);
        check("R8 chain", 32'(old), 0);
        test_mode = 1'b0;
    endtask

    task automatic t_transparent();
        test_mode = 1'b0;
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            pin_in   = 4'(p * 5 + 3);
            core_out = 4'(~(p * 3));
            #1;
            check("R1 pin_out", 32'(pin_out), 32'(core_out));
            check("R1 core_in", 32'(core_in), 32'(pin_in));
        end
    endtask

    task automatic t_capture();
        logic [LEN-1:0] old;
        @(negedge clk);
        pin_in = 4'hA; core_out = 4'h6; cap_en = 1'b1;
        @(negedge clk);
        cap_en = 1'b0;
        check("R3 tdo after capture", 32'(tdo), 32'(core_out[NUM_OUT-1]));
        shift_chain('0, old);
        check("R3 R4 captured chain", 32'(old), 32'({4'h6, 4'hA}));
    endtask

    task automatic t_update_hold();
        logic [LEN-1:0] old;
        shift_chain({4'h9, 4'h5}, old);
        pulse_update();
        test_mode = 1'b1;
        #1;
        check("R2 pin_out", 32'(pin_out), 32'h9);
        check("R2 core_in", 32'(core_in), 32'h5);
        shift_chain({4'h2, 4'hC}, old);
        check("R5 hold pin_out", 32'(pin_out), 32'h9);
        check("R5 hold core_in", 32'(core_in), 32'h5);
        check("R4 unload", 32'(old), 32'h95);
        pulse_update();
        check("R5 new pin_out", 32'(pin_out), 32'h2);
        check("R5 new core_in", 32'(core_in), 32'hC);
        test_mode = 1'b0;
    endtask

    task automatic t_cap_shift();
        logic [LEN-1:0] old;
        shift_chain(8'hFF, old);
        @(negedge clk);
        pin_in = 4'h3; core_out = 4'h4;
        cap_en = 1'b1; shift_en = 1'b1; tdi = 1'b0;
        @(negedge clk);
        cap_en = 1'b0; shift_en = 1'b0;
        shift_chain('0, old);
        check("R6 capture over shift", 32'(old), 32'h43);
    endtask

    task automatic t_upd_shift();
        logic [LEN-1:0] old;
        shift_chain({4'hB, 4'h7}, old);
        @(negedge clk);
        upd_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
        @(negedge clk);
        upd_en = 1'b0; shift_en = 1'b0;
        test_mode = 1'b1;
        #1;
        check("R7 pin_out pre-shift", 32'(pin_out), 32'hB);
        check("R7 core_in pre-shift", 32'(core_in), 32'h7);
        test_mode = 1'b0;
        #1;
        check("R1 after update", 32'(pin_out), 32'(core_out));
    endtask

    task automatic t_latency();
        logic [LEN-1:0] old;
        shift_chain('0, old);
        for (int i = 0; i < LEN; i++) begin
            @(negedge clk);
            if (i == LEN - 1) check("R9 not early", 32'(tdo), 0);
            tdi = (i == 0);
            shift_en = 1'b1;
        end
        @(negedge clk);
        shift_en = 1'b0;
        check("R9 arrival", 32'(tdo), 1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_transparent();
        t_capture();
        t_update_hold();
        t_cap_shift();
        t_upd_shift();
        t_latency();
        finish_run();
    end

endmodule